// File: doc/BRIEF.md
# Packed SIMD Averaging Unit

This unit takes two 128-bit vector operands and a 32-bit instruction word in the same cycle. Each lane of the result is the average of the matching lanes of the two operands. The instruction chooses the lane size (8, 16, 32 or 64 bits), whether lanes are read as two's-complement or unsigned, and whether the average rounds down or rounds half up. The average is formed at lane width with no wider sum. Each operand lane is shifted right by one bit, the two halves are added, and a single correction bit enters the lane's lowest adder segment. That bit is the AND of the two discarded low bits in floor mode and their OR in rounding mode. The adder is a chain of 8-bit segments. The lane size decides at which segments the carry chain is cut.

Input and output use a valid/ready handshake. An accepted word whose encoding is not an averaging operation produces no result. Instead it raises a one-cycle error pulse and leaves the result register untouched. A legal word produces its result one cycle after acceptance. The result comes with the destination register index and the two source indices taken from the same word. It stays on the outputs until the consumer takes it.

Top module: `simd_avg_unit`

## Requirements
- R1: The two lowest subcode bits `in_insn[16:15]` select the lane size: 00 gives sixteen 8-bit lanes, 01 eight 16-bit lanes, 10 four 32-bit lanes and 11 two 64-bit lanes.
- R2: In floor mode, every result lane equals floor((a+b)/2) computed without overflow. In particular, equal operand lanes return that same value.
- R3: In rounding mode, every result lane equals floor((a+b+1)/2) computed without overflow.
- R4: Subcode bit `in_insn[17]` = 0 reads lanes as two's-complement, and 1 reads them as unsigned. For example, signed 8-bit -128 with 127 gives 0xFF in floor mode and 0x00 in rounding mode. Unsigned 0xFF with 0xFF gives 0xFF in both modes.
- R5: No carry crosses a lane boundary. For example, unsigned floor averaging of every 0xFF byte with 0x01 gives 0x80 in each byte.
- R6: A word is legal when `in_insn[31:20]` = 0111_0000_0110 and the subcode `in_insn[19:15]` lies in 01000..01111 (floor) or 10000..10111 (round). The outputs carry the fields of the word: `out_dst` = `in_insn[4:0]`, `out_srca` = `in_insn[9:5]` and `out_srcb` = `in_insn[14:10]`.
- R7: When an illegal word is accepted, `out_err` is high for the following cycle and `out_valid` is low. `out_data` and the index outputs keep their previous values.
- R8: A transfer happens when `in_valid` and `in_ready` are both high. `in_ready` is high whenever `out_valid` is low or `out_ready` is high. The result of a legal transfer shows on the outputs with `out_valid` high from the next cycle on.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and the index outputs hold steady and `in_ready` is low.
- R10: After reset, `out_valid` and `out_err` are low, `out_data` is zero and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Instruction and operands are present |
| in_ready | output | 1 | Unit can take a new instruction |
| in_insn | input | 32 | Instruction word |
| in_opa | input | 128 | First vector operand |
| in_opb | input | 128 | Second vector operand |
| out_ready | input | 1 | Consumer takes the result |
| out_valid | output | 1 | Result is present |
| out_data | output | 128 | Averaged vector |
| out_dst | output | 5 | Destination register index |
| out_srca | output | 5 | First source register index |
| out_srcb | output | 5 | Second source register index |
| out_err | output | 1 | One-cycle pulse after an illegal word is accepted |

## Verification
A broken segment carry chain or halving mux shows up on `out_data` in the cycle right after the operands are accepted. It corrupts only the lanes of the size that is wired wrongly, so the bench runs every subcode against a widened-sum model. A stuck or stale output-valid state has two visible effects. A result held under back-pressure changes or is lost. Or `in_ready` stays low, so the next word is not taken, within one cycle of the faulty transfer. A decoder that accepts a bad word shows `out_valid` where `out_err` was expected, and `out_data` is overwritten on the next cycle.

// File: rtl/simd_avg_pkg.sv
package simd_avg_pkg;

  localparam int VEC_W   = 128;
  localparam int SEG_W   = 8;
  localparam int IDX_W   = 5;
  localparam int NUM_SZ  = 4;
  localparam int SUB_W   = 5;
  localparam int INSN_W  = 32;
  localparam int MAJ_W   = INSN_W - SUB_W - 3 * IDX_W;
  localparam logic [MAJ_W-1:0] AVG_MAJOR = 12'b0111_0000_0110;

  typedef enum logic [1:0] {
    LS_8  = 2'd0,
    LS_16 = 2'd1,
    LS_32 = 2'd2,
    LS_64 = 2'd3
  } lane_sz_e;

  typedef struct packed {
    logic             legal;
    logic             rnd;
    logic             uns;
    lane_sz_e         sz;
    logic [IDX_W-1:0] rb;
    logic [IDX_W-1:0] ra;
    logic [IDX_W-1:0] rd;
  } avg_op_t;

endpackage

// File: rtl/simd_avg_decode.sv
module simd_avg_decode
  import simd_avg_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output avg_op_t           op
);

  localparam int SUB_LSB = 3 * IDX_W;
  localparam int MAJ_LSB = SUB_LSB + SUB_W;

  logic [SUB_W-1:0] sub;
  logic [MAJ_W-1:0] major;

  always_comb begin
    sub      = insn[SUB_LSB +: SUB_W];
    major    = insn[MAJ_LSB +: MAJ_W];
    // group field: 01 floor, 10 round; 00 and 11 are not averaging ops
    op.legal = (major == AVG_MAJOR) && (sub[4] ^ sub[3]);
    op.rnd   = sub[4];
    op.uns   = sub[2];
    op.sz    = lane_sz_e'(sub[1:0]);
    op.rb    = insn[2*IDX_W +: IDX_W];
    op.ra    = insn[IDX_W +: IDX_W];
    op.rd    = insn[0 +: IDX_W];
  end

endmodule

// File: rtl/simd_avg_halve.sv
module simd_avg_halve
  import simd_avg_pkg::*;
#(
  parameter int VW  = VEC_W,
  parameter int SW  = SEG_W,
  parameter int NSZ = NUM_SZ
) (
  input  logic [VW-1:0]       a,
  input  logic [VW-1:0]       b,
  input  lane_sz_e            sz,
  input  logic                uns,
  input  logic                rnd,
  output logic [VW-1:0]       ha,
  output logic [VW-1:0]       hb,
  output logic [VW/SW-1:0]    seg_cin,
  output logic [VW/SW-1:0]    seg_start
);

  localparam int NSEG = VW / SW;

  logic [NSZ-1:0][VW-1:0]   ha_all;
  logic [NSZ-1:0][VW-1:0]   hb_all;
  logic [NSZ-1:0][NSEG-1:0] cin_all;
  logic [NSZ-1:0][NSEG-1:0] start_all;

  for (genvar s = 0; s < NSZ; s++) begin : g_sz
    localparam int LW = SW << s;
    localparam int NL = VW / LW;

    // per-lane halving: logical or arithmetic shift right by one
    for (genvar l = 0; l < NL; l++) begin : g_lane
      assign ha_all[s][l*LW +: LW] = {~uns & a[l*LW+LW-1], a[l*LW+1 +: LW-1]};
      assign hb_all[s][l*LW +: LW] = {~uns & b[l*LW+LW-1], b[l*LW+1 +: LW-1]};
    end

    // segments that open a lane take the correction bit as carry-in
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
      localparam bit IS_START = ((g * SW) % LW) == 0;
      assign start_all[s][g] = IS_START;
      if (IS_START) begin : g_open
        assign cin_all[s][g] = rnd ? (a[g*SW] | b[g*SW]) : (a[g*SW] & b[g*SW]);
      end else begin : g_inner
        assign cin_all[s][g] = 1'b0;
      end
    end
  end

  assign ha        = ha_all[sz];
  assign hb        = hb_all[sz];
  assign seg_cin   = cin_all[sz];
  assign seg_start = start_all[sz];

endmodule

// File: rtl/simd_avg_seg_add.sv
module simd_avg_seg_add
  import simd_avg_pkg::*;
#(
  parameter int VW = VEC_W,
  parameter int SW = SEG_W
) (
  input  logic [VW-1:0]    ha,
  input  logic [VW-1:0]    hb,
  input  logic [VW/SW-1:0] seg_cin,
  input  logic [VW/SW-1:0] seg_start,
  output logic [VW-1:0]    sum
);

  localparam int NSEG = VW / SW;

  logic [NSEG-2:0] carry;
  logic [NSEG-1:0] ci;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    if (g == 0) begin : g_first
      assign ci[g] = seg_start[g] ? seg_cin[g] : 1'b0;
    end else begin : g_rest
      assign ci[g] = seg_start[g] ? seg_cin[g] : carry[g-1];
    end

    if (g < NSEG - 1) begin : g_chain
      assign {carry[g], sum[g*SW +: SW]} =
        {1'b0, ha[g*SW +: SW]} + {1'b0, hb[g*SW +: SW]} + {{SW{1'b0}}, ci[g]};
    end else begin : g_top
      assign sum[g*SW +: SW] =
        ha[g*SW +: SW] + hb[g*SW +: SW] + {{(SW-1){1'b0}}, ci[g]};
    end
  end

endmodule

// File: rtl/simd_avg_out_reg.sv
module simd_avg_out_reg
  import simd_avg_pkg::*;
#(
  parameter int VW = VEC_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          legal,
  input  logic [VW-1:0] sum,
  input  logic [IW-1:0] rd,
  input  logic [IW-1:0] ra,
  input  logic [IW-1:0] rb,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [VW-1:0] out_data,
  output logic [IW-1:0] out_dst,
  output logic [IW-1:0] out_srca,
  output logic [IW-1:0] out_srcb,
  output logic          out_err
);

  logic          vld_q, vld_d;
  logic          err_q, err_d;
  logic          acc, ld_en;
  logic [VW-1:0] data_q, data_d;
  logic [IW-1:0] rd_q, rd_d, ra_q, ra_d, rb_q, rb_d;

  always_comb begin
    in_ready = !vld_q || out_ready;
    acc      = in_valid && in_ready;
    ld_en    = acc && legal;
    vld_d    = acc ? legal : (vld_q && !out_ready);
    err_d    = acc && !legal;
    data_d   = ld_en ? sum : data_q;
    rd_d     = ld_en ? rd  : rd_q;
    ra_d     = ld_en ? ra  : ra_q;
    rb_d     = ld_en ? rb  : rb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
      data_q <= '0;
      rd_q   <= '0;
      ra_q   <= '0;
      rb_q   <= '0;
    end else begin
      vld_q  <= vld_d;
      err_q  <= err_d;
      data_q <= data_d;
      rd_q   <= rd_d;
      ra_q   <= ra_d;
      rb_q   <= rb_d;
    end
  end

  assign out_valid = vld_q;
  assign out_err   = err_q;
  assign out_data  = data_q;
  assign out_dst   = rd_q;
  assign out_srca  = ra_q;
  assign out_srcb  = rb_q;

endmodule

// File: rtl/simd_avg_unit.sv
module simd_avg_unit
  import simd_avg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] in_insn,
  input  logic [VEC_W-1:0]  in_opa,
  input  logic [VEC_W-1:0]  in_opb,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [VEC_W-1:0]  out_data,
  output logic [IDX_W-1:0]  out_dst,
  output logic [IDX_W-1:0]  out_srca,
  output logic [IDX_W-1:0]  out_srcb,
  output logic              out_err
);

  localparam int NSEG = VEC_W / SEG_W;

  // reset: asserted at once, released on a clock edge
  logic rst_meta_n, rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  avg_op_t          op;
  logic [VEC_W-1:0] ha, hb, sum;
  logic [NSEG-1:0]  seg_cin, seg_start;

  simd_avg_decode u_dec (
    .insn (in_insn),
    .op   (op)
  );

  simd_avg_halve #(.VW(VEC_W), .SW(SEG_W), .NSZ(NUM_SZ)) u_halve (
    .a         (in_opa),
    .b         (in_opb),
    .sz        (op.sz),
    .uns       (op.uns),
    .rnd       (op.rnd),
    .ha        (ha),
    .hb        (hb),
    .seg_cin   (seg_cin),
    .seg_start (seg_start)
  );

  simd_avg_seg_add #(.VW(VEC_W), .SW(SEG_W)) u_add (
    .ha        (ha),
    .hb        (hb),
    .seg_cin   (seg_cin),
    .seg_start (seg_start),
    .sum       (sum)
  );

  simd_avg_out_reg #(.VW(VEC_W), .IW(IDX_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .legal     (op.legal),
    .sum       (sum),
    .rd        (op.rd),
    .ra        (op.ra),
    .rb        (op.rb),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_dst   (out_dst),
    .out_srca  (out_srca),
    .out_srcb  (out_srcb),
    .out_err   (out_err)
  );

endmodule

// File: rtl/simd_avg_unit_chk.sv
module simd_avg_unit_chk
  import simd_avg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [INSN_W-1:0] in_insn,
  input logic [VEC_W-1:0]  in_opa,
  input logic [VEC_W-1:0]  in_opb,
  input logic              out_ready,
  input logic              out_valid,
  input logic [VEC_W-1:0]  out_data,
  input logic [IDX_W-1:0]  out_dst,
  input logic              out_err
);

  logic acc, word_ok;
  assign acc     = in_valid && in_ready;
  assign word_ok = (in_insn[31:20] == AVG_MAJOR) &&
                   ((in_insn[19:18] == 2'b01) || (in_insn[19:18] == 2'b10));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_dst)));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_idle_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_dst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && word_ok) |=> (out_valid && out_dst == $past(in_insn[4:0])));

  p_illegal_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !word_ok) |=> (!out_valid && out_err && $stable(out_data)));

  p_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> !out_valid);

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && word_ok && in_opa == in_opb) |=> (out_data == $past(in_opa)));

endmodule

bind simd_avg_unit simd_avg_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_insn   (in_insn),
  .in_opa    (in_opa),
  .in_opb    (in_opb),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_dst   (out_dst),
  .out_err   (out_err)
);

// File: tb/simd_avg_unit_tb_top.sv
module simd_avg_unit_tb_top;

  localparam time CLK_P = 20ns;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [31:0]  in_insn;
  logic [127:0] in_opa, in_opb;
  logic         out_ready;
  logic         out_valid;
  logic [127:0] out_data;
  logic [4:0]   out_dst, out_srca, out_srcb;
  logic         out_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  simd_avg_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_insn   (in_insn),
    .in_opa    (in_opa),
    .in_opb    (in_opb),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_dst   (out_dst),
    .out_srca  (out_srca),
    .out_srcb  (out_srcb),
    .out_err   (out_err)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] sub, input logic [4:0] rb,
                                     input logic [4:0] ra, input logic [4:0] rd);
    return {12'b0111_0000_0110, sub, rb, ra, rd};
  endfunction

  // widened-sum model of one subcode
  function automatic logic [127:0] ref_avg(input logic [4:0] sub,
                                           input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r;
    int w;
    r = '0;
    w = 8 << sub[1:0];
    for (int l = 0; l < 128 / w; l++) begin
      logic signed [65:0] ea, eb, s;
      ea = '0;
      eb = '0;
      for (int i = 0; i < w; i++) begin
        ea[i] = a[l*w+i];
        eb[i] = b[l*w+i];
      end
      if (!sub[2]) begin
        for (int i = w; i < 66; i++) begin
          ea[i] = a[l*w+w-1];
          eb[i] = b[l*w+w-1];
        end
      end
      s = ea + eb + (sub[4] ? 66'sd1 : 66'sd0);
      s = s >>> 1;
      for (int i = 0; i < w; i++) r[l*w+i] = s[i];
    end
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // one legal transfer, result checked the cycle after acceptance
  task automatic run_one(input string req, input logic [4:0] sub,
                         input logic [127:0] a, input logic [127:0] b,
                         input logic [4:0] rd);
    logic [4:0] ra, rb;
    ra = rd + 5'd3;
    rb = rd + 5'd9;
    @(negedge clk);
    in_valid = 1'b1;
    in_insn  = mk(sub, rb, ra, rd);
    in_opa   = a;
    in_opb   = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, {127'd0, out_valid}, 128'd1);
    chk(req, out_data, ref_avg(sub, a, b));
    chk({req, " dst R6"}, {123'd0, out_dst}, {123'd0, rd});
    chk({req, " srcs R6"}, {118'd0, out_srcb, out_srca}, {118'd0, rb, ra});
  endtask

  task automatic t_reset();
    chk("R10 out_valid", {127'd0, out_valid}, 128'd0);
    chk("R10 out_err",   {127'd0, out_err},   128'd0);
    chk("R10 in_ready",  {127'd0, in_ready},  128'd1);
    chk("R10 out_data",  out_data, 128'd0);
  endtask

  task automatic t_extremes();
    // R4 signed -128 with 127: floor -> 0xFF, round -> 0x00
    run_one("R4 s8 floor", 5'b01000, {16{8'h80}}, {16{8'h7F}}, 5'd1);
    chk("R4 s8 floor literal", out_data, {16{8'hFF}});
    run_one("R4 s8 round", 5'b10000, {16{8'h80}}, {16{8'h7F}}, 5'd2);
    chk("R4 s8 round literal", out_data, 128'd0);
    run_one("R4 u8 ff floor", 5'b01100, {16{8'hFF}}, {16{8'hFF}}, 5'd3);
    chk("R4 u8 ff floor literal", out_data, {16{8'hFF}});
    run_one("R4 u8 ff round", 5'b10100, {16{8'hFF}}, {16{8'hFF}}, 5'd4);
    chk("R4 u8 ff round literal", out_data, {16{8'hFF}});
    for (int s = 0; s < 4; s++) begin
      logic [127:0] mn, mx;
      int w;
      w  = 8 << s;
      mn = '0;
      mx = '0;
      for (int l = 0; l < 128 / w; l++) begin
        mn[l*w + w - 1] = 1'b1;
        for (int i = 0; i < w - 1; i++) mx[l*w + i] = 1'b1;
      end
      run_one("R2 signed min/max floor", {3'b010, s[1:0]}, mn, mx, 5'd5);
      run_one("R3 signed min/max round", {3'b100, s[1:0]}, mn, mx, 5'd6);
      run_one("R2 signed min/min floor", {3'b010, s[1:0]}, mn, mn, 5'd7);
      run_one("R3 unsigned ones round",  {3'b101, s[1:0]}, '1, '1, 5'd8);
    end
  endtask

  task automatic t_lane_isolation();
    run_one("R5 u8 ff+01", 5'b01100, {16{8'hFF}}, {16{8'h01}}, 5'd10);
    chk("R5 u8 literal", out_data, {16{8'h80}});
    run_one("R5 u16 ffff+0001 round", 5'b10101, {8{16'hFFFF}}, {8{16'h0001}}, 5'd11);
    chk("R5 u16 literal", out_data, {8{16'h8000}});
    run_one("R5 u32 floor", 5'b01110, {4{32'hFFFF_FFFF}}, {4{32'h0000_0003}}, 5'd12);
    run_one("R5 u64 round", 5'b10111, {2{64'hFFFF_FFFF_FFFF_FFFF}}, {2{64'h1}}, 5'd13);
  endtask

  task automatic t_sweep();
    // R1 R2 R3 R4: every legal subcode with random operands
    for (int s = 8; s < 24; s++) begin
      for (int k = 0; k < 24; k++) begin
        run_one(s < 16 ? "R1 R2 sweep floor" : "R1 R3 sweep round",
                5'(s), rnd128(), rnd128(), 5'(k));
      end
    end
  endtask

  task automatic t_backpressure();
    logic [127:0] a1, b1, a2, b2;
    a1 = rnd128(); b1 = rnd128(); a2 = rnd128(); b2 = rnd128();
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_insn   = mk(5'b01001, 5'd1, 5'd2, 5'd20);
    in_opa    = a1;
    in_opb    = b1;
    @(posedge clk);
    @(negedge clk);
    in_insn = mk(5'b10110, 5'd3, 5'd4, 5'd21);
    in_opa  = a2;
    in_opb  = b2;
    chk("R8 first result", out_data, ref_avg(5'b01001, a1, b1));
    chk("R9 stall ready low", {127'd0, in_ready}, 128'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 data held", out_data, ref_avg(5'b01001, a1, b1));
    chk("R9 valid held", {127'd0, out_valid}, 128'd1);
    chk("R9 dst held", {123'd0, out_dst}, 128'd20);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 second result", out_data, ref_avg(5'b10110, a2, b2));
    chk("R8 second dst", {123'd0, out_dst}, 128'd21);
    @(negedge clk);
    chk("R8 drained", {127'd0, out_valid}, 128'd0);
  endtask

  task automatic t_illegal();
    logic [127:0] keep;
    logic [31:0] bad [3];
    bad[0] = {12'b0111_0001_0110, 5'b01000, 15'h1234};
    bad[1] = mk(5'b00111, 5'd1, 5'd2, 5'd3);
    bad[2] = mk(5'b11000, 5'd1, 5'd2, 5'd3);
    run_one("R6 legal before illegal", 5'b10010, rnd128(), rnd128(), 5'd30);
    keep = out_data;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_insn  = bad[k];
      in_opa   = rnd128();
      in_opb   = rnd128();
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R7 err pulse", {127'd0, out_err}, 128'd1);
      chk("R7 no valid", {127'd0, out_valid}, 128'd0);
      chk("R7 data kept", out_data, keep);
      chk("R7 dst kept", {123'd0, out_dst}, 128'd30);
      @(negedge clk);
      chk("R7 err one cycle", {127'd0, out_err}, 128'd0);
    end
  endtask

  initial begin
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_insn   = '0;
    in_opa    = '0;
    in_opb    = '0;
    out_ready = 1'b1;
    void'($urandom(32'h5EED_0A76));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_extremes();
    t_lane_isolation();
    t_sweep();
    t_backpressure();
    t_illegal();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule